// File: doc/BRIEF.md
# Two-Pass Analog Conversion Sequencer

This block masters a small 8-bit register port on an analog converter and carries out one complete conversion for each accepted request. A request names an input channel from 0 to 15, a 2-bit range code and a flag choosing single-ended or differential input. The sequencer packs these into a command byte and writes it to the converter. It then polls the converter's status byte until the ready bit appears.

The converter's multiplexer needs time to settle after a channel change, so the first conversion is thrown away. The same command is written again, the status is polled a second time, and then the low and high result bytes are read. The 16-bit sample is returned with a one-cycle completion pulse. For the two bipolar range codes the sample is offset by half scale.

Each polling pass is limited. If the ready bit never appears, the request still completes, with a timeout flag set.

Top module: `adc_two_pass_seq`

## Requirements
- R1: `reqReady` is high exactly when the block is idle, including straight after reset. A request is taken on a cycle where `reqValid` and `reqReady` are both high. Each taken request produces exactly one `doneValid` pulse, one cycle long.
- R2: The command byte carries the following fields. Bit 7 is 1 for single-ended input and 0 for differential. Bit 6 is bit 0 of the reduced channel. Bits 5:4 are the reduced channel divided by 2. Bits 3:2 are the range code. Bits 1:0 are 0. The reduced channel is the channel number modulo 8.
- R3: Channels 0–7 use bus addresses 0–3 and channels 8–15 use addresses 4–7. Address bit 2 selects the window, and bits 1:0 select the register within it.
- R4: The command is written at register 2. Status is polled by reading register 3, and only bit 7 of that byte (1 = ready) is decoded. Status polling starts with the read that follows each command write.
- R5: The command is written twice, and each write is followed by its own polling pass. Only after the second pass are register 0 (low byte) and then register 1 (high byte) read. The sample returned is the second conversion's result.
- R6: For range codes 0 and 1, the returned sample is the raw result plus 0x8000, modulo 2^16. For range codes 2 and 3, it is the raw result unchanged.
- R7: If `POLL_LIMIT` status reads in one pass all show not-ready, the request completes with `doneTimeout` high. In that case the returned data is the range correction applied to an all-zero raw sample.
- R8: If the ready bit appears on the `POLL_LIMIT`-th read of a pass, the pass completes normally, and no timeout is flagged.
- R9: The poll count restarts for the second pass, so each pass may use up to `POLL_LIMIT` status reads on its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Block idle and able to take a request |
| reqChan | input | 4 | Channel number 0–15 |
| reqRange | input | 2 | Range code; 0 and 1 are bipolar |
| reqSingle | input | 1 | 1 = single-ended, 0 = differential |
| busAddr | output | 3 | Register address on the converter port |
| busWe | output | 1 | Write strobe, one cycle |
| busRe | output | 1 | Read strobe; data is returned on `busRdata` in the next cycle |
| busWdata | output | 8 | Write data (the command byte) |
| busRdata | input | 8 | Read data, valid one cycle after `busRe` |
| doneValid | output | 1 | One-cycle completion pulse |
| doneData | output | 16 | Corrected sample |
| doneTimeout | output | 1 | Request ended on a polling timeout |

## Verification
The hardest situations to reach from the ports are timeouts that occur in the second polling pass, and a ready bit that arrives on the very last allowed poll. Both depend on exact counts of status reads. The bench drives a converter model that holds a separate not-ready count for each pass and sets the low seven status bits to ones while busy. The bench also builds the block with a small poll limit. Requests are issued with busy counts of limit−1, exactly the limit, and limit-exceeding in the second pass only. A first-pass result that differs from the second one shows whether the discarded conversion ever reaches the output.

// File: rtl/adc2p_pkg.sv
package adc2p_pkg;

  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 2 * BYTE_W;
  localparam int REG_W    = 2;

  localparam logic [REG_W-1:0] REG_LO   = 2'd0;
  localparam logic [REG_W-1:0] REG_HI   = 2'd1;
  localparam logic [REG_W-1:0] REG_CMD  = 2'd2;
  localparam logic [REG_W-1:0] REG_STAT = 2'd3;

  typedef struct packed {
    logic             latchReq;
    logic             capLo;
    logic             capHi;
    logic [REG_W-1:0] regSel;
  } dpCtrl_t;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_POLL_RD, S_POLL_CHK,
    S_LO_RD, S_LO_CAP, S_HI_RD, S_HI_CAP, S_DONE
  } seqState_t;

endpackage

// File: rtl/adc2p_ctrl.sv
module adc2p_ctrl
  import adc2p_pkg::*;
#(
  parameter int POLL_LIMIT = 100000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  input  logic    statReady,
  output dpCtrl_t dp,
  output logic    busWe,
  output logic    busRe,
  output logic    doneValid,
  output logic    doneTimeout
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POLL_LIMIT);

  seqState_t  state;
  logic       secondPass;
  logic       timedOut;
  logic [CNT_W-1:0] pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= S_IDLE;
      secondPass <= 1'b0;
      timedOut   <= 1'b0;
      pollCnt    <= '0;
    end else begin
      case (state)
        S_IDLE: if (reqValid) begin
          state      <= S_CMD;
          secondPass <= 1'b0;
          timedOut   <= 1'b0;
        end
        S_CMD: begin
          pollCnt <= '0;
          state   <= S_POLL_RD;
        end
        S_POLL_RD: begin
          pollCnt <= pollCnt + 1'b1;
          state   <= S_POLL_CHK;
        end
        S_POLL_CHK: begin
          if (statReady) begin
            if (secondPass) state <= S_LO_RD;
            else begin
              secondPass <= 1'b1;
              state      <= S_CMD;
            end
          end else if (pollCnt == CNT_MAX) begin
            timedOut <= 1'b1;
            state    <= S_DONE;
          end else begin
            state <= S_POLL_RD;
          end
        end
        S_LO_RD:  state <= S_LO_CAP;
        S_LO_CAP: state <= S_HI_RD;
        S_HI_RD:  state <= S_HI_CAP;
        S_HI_CAP: state <= S_DONE;
        S_DONE:   state <= S_IDLE;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    dp          = '0;
    dp.regSel   = REG_STAT;
    busWe       = 1'b0;
    busRe       = 1'b0;
    reqReady    = (state == S_IDLE);
    doneValid   = (state == S_DONE);
    doneTimeout = (state == S_DONE) && timedOut;
    case (state)
      S_IDLE:    dp.latchReq = reqValid;
      S_CMD:     begin busWe = 1'b1; dp.regSel = REG_CMD; end
      S_POLL_RD: begin busRe = 1'b1; dp.regSel = REG_STAT; end
      S_LO_RD:   begin busRe = 1'b1; dp.regSel = REG_LO; end
      S_LO_CAP:  dp.capLo = 1'b1;
      S_HI_RD:   begin busRe = 1'b1; dp.regSel = REG_HI; end
      S_HI_CAP:  dp.capHi = 1'b1;
      default:   ;
    endcase
  end

  // R1: completion is a single-cycle pulse
  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R1: no bus traffic while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!busWe && !busRe));

  // R4: write and read never in the same cycle
  p_we_re_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(busWe && busRe));

  // R7: poll count never exceeds its limit
  p_poll_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= CNT_MAX);

  // R7: timeout flag only with completion
  p_timeout_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    doneTimeout |-> doneValid);

endmodule

// File: rtl/adc2p_dp.sv
module adc2p_dp
  import adc2p_pkg::*;
#(
  parameter int CHAN_W  = 4,
  parameter int RANGE_W = 2,
  parameter int ADDR_W  = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             dp,
  input  logic [CHAN_W-1:0]   reqChan,
  input  logic [RANGE_W-1:0]  reqRange,
  input  logic                reqSingle,
  input  logic [BYTE_W-1:0]   busRdata,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [BYTE_W-1:0]   busWdata,
  output logic                statReady,
  output logic [SAMPLE_W-1:0] doneData
);

  localparam int RED_W = CHAN_W - 1;
  localparam logic [SAMPLE_W-1:0] HALF_SCALE = SAMPLE_W'(1) << (SAMPLE_W - 1);

  logic [CHAN_W-1:0]   chanReg;
  logic [RANGE_W-1:0]  rangeReg;
  logic                singleReg;
  logic [SAMPLE_W-1:0] rawSample;
  logic [RED_W-1:0]    redChan;
  logic                bipolar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanReg   <= '0;
      rangeReg  <= '0;
      singleReg <= 1'b0;
      rawSample <= '0;
    end else begin
      if (dp.latchReq) begin
        chanReg   <= reqChan;
        rangeReg  <= reqRange;
        singleReg <= reqSingle;
        rawSample <= '0;
      end
      if (dp.capLo) rawSample[BYTE_W-1:0]        <= busRdata;
      if (dp.capHi) rawSample[SAMPLE_W-1:BYTE_W] <= busRdata;
    end
  end

  assign redChan   = chanReg[RED_W-1:0];
  assign busWdata  = {singleReg, redChan[0], redChan[RED_W-1:1], rangeReg, 2'b00};
  assign busAddr   = {chanReg[CHAN_W-1], dp.regSel};
  assign statReady = busRdata[BYTE_W-1];
  assign bipolar   = (rangeReg < RANGE_W'(2));
  assign doneData  = bipolar ? (rawSample + HALF_SCALE) : rawSample;

  // R5: the two halves are never captured together
  p_cap_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(dp.capLo && dp.capHi));

endmodule

// File: rtl/adc_two_pass_seq.sv
module adc_two_pass_seq
  import adc2p_pkg::*;
#(
  parameter int POLL_LIMIT = 100000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [3:0]  reqChan,
  input  logic [1:0]  reqRange,
  input  logic        reqSingle,
  output logic [2:0]  busAddr,
  output logic        busWe,
  output logic        busRe,
  output logic [7:0]  busWdata,
  input  logic [7:0]  busRdata,
  output logic        doneValid,
  output logic [15:0] doneData,
  output logic        doneTimeout
);

  dpCtrl_t dpCtl;
  logic    statReady;

  adc2p_ctrl #(.POLL_LIMIT(POLL_LIMIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .statReady(statReady), .dp(dpCtl), .busWe(busWe), .busRe(busRe),
    .doneValid(doneValid), .doneTimeout(doneTimeout)
  );

  adc2p_dp #(.CHAN_W(4), .RANGE_W(2), .ADDR_W(3)) i_dp (
    .clk(clk), .rstN(rstN), .dp(dpCtl), .reqChan(reqChan), .reqRange(reqRange),
    .reqSingle(reqSingle), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .statReady(statReady), .doneData(doneData)
  );

  // R4: command writes land on register 2
  p_cmd_offset_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> (busAddr[1:0] == REG_CMD));

  // R4: every command write is followed by a status read
  p_stat_follows_r4: assert property (@(posedge clk) disable iff (!rstN)
    busWe |=> (busRe && busAddr[1:0] == REG_STAT));

endmodule

// File: tb/test_adc_two_pass_seq.sv
module test_adc_two_pass_seq;

  localparam int LIM = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [3:0] reqChan = '0;
  logic [1:0] reqRange = '0;
  logic reqSingle = 1'b0;
  logic [2:0] busAddr;
  logic busWe, busRe;
  logic [7:0] busWdata;
  logic [7:0] busRdata = '0;
  logic doneValid;
  logic [15:0] doneData;
  logic doneTimeout;

  always #2 clk = ~clk;

  adc_two_pass_seq #(.POLL_LIMIT(LIM)) i_adc_two_pass_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqChan(reqChan), .reqRange(reqRange), .reqSingle(reqSingle),
    .busAddr(busAddr), .busWe(busWe), .busRe(busRe), .busWdata(busWdata),
    .busRdata(busRdata), .doneValid(doneValid), .doneData(doneData),
    .doneTimeout(doneTimeout)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // converter model: expectations set by the driver
  logic [7:0]  expCmd = '0;
  logic        expWin = 1'b0;
  int          busy1 = 0, busy2 = 0;
  logic [15:0] goodRaw = '0;

  int          wrCnt = 0, busyLeft = 0, modelErr = 0;
  bit          loSeen = 0, orderBad = 0;
  logic [15:0] convVal = '0;

  always @(posedge clk) begin
    if (reqValid && reqReady) begin
      wrCnt <= 0; modelErr <= 0; loSeen <= 0; orderBad <= 0;
    end
    if (busWe) begin
      if (busAddr != {expWin, 2'd2} || busWdata != expCmd) modelErr <= modelErr + 1;
      wrCnt    <= wrCnt + 1;
      busyLeft <= (wrCnt == 0) ? busy1 : busy2;
      convVal  <= (wrCnt == 0) ? 16'hDEAD : goodRaw;
    end
    if (busRe) begin
      if (busAddr[2] != expWin) modelErr <= modelErr + 1;
      case (busAddr[1:0])
        2'd3: if (busyLeft == 0) busRdata <= 8'h80;
              else begin busRdata <= 8'h7F; busyLeft <= busyLeft - 1; end
        2'd0: begin busRdata <= convVal[7:0]; loSeen <= 1; end
        2'd1: begin busRdata <= convVal[15:8]; if (!loSeen) orderBad <= 1; end
        default: modelErr <= modelErr + 1;
      endcase
    end
  end

  typedef struct {
    logic [15:0] data;
    bit          tmo;
    int          writes;
    string       tag;
  } expItem_t;
  expItem_t sb[$];

  task automatic doReq(input logic [3:0] ch, input logic [1:0] rg, input bit se,
                       input logic [15:0] raw, input int b1, input int b2,
                       input string tag);
    expItem_t it;
    logic [2:0] red;
    bit t1, t2;
    red = ch[2:0];
    t1 = (b1 >= LIM);
    t2 = !t1 && (b2 >= LIM);
    it.tmo    = t1 || t2;
    it.writes = t1 ? 1 : 2;
    it.data   = it.tmo ? 16'h0000 : raw;
    if (rg < 2) it.data = it.data + 16'h8000;
    it.tag = tag;
    while (!reqReady) @(negedge clk);
    sb.push_back(it);
    expCmd  = {se, red[0], red[2:1], rg, 2'b00};
    expWin  = ch[3];
    busy1   = b1; busy2 = b2; goodRaw = raw;
    reqChan = ch; reqRange = rg; reqSingle = se;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R1", "ready low while busy", reqReady, 0);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (doneValid) begin
        if (sb.size() == 0) chk(0, "R1", "unexpected done", 1, 0);
        else begin
          expItem_t e;
          e = sb.pop_front();
          chk(doneData == e.data, e.tag, "sample", doneData, e.data);
          chk(doneTimeout == e.tmo, "R7", "timeout flag", doneTimeout, e.tmo);
          chk(wrCnt == e.writes, "R5", "command writes", wrCnt, e.writes);
          chk(modelErr == 0, "R2", "command/window errors (R3)", modelErr, 0);
          if (!e.tmo) chk(!orderBad && loSeen, "R5", "low before high", orderBad, 0);
          @(negedge clk);
          chk(doneValid == 1'b0, "R1", "done pulse width", doneValid, 0);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reset ready", reqReady, 1);
    chk(doneValid == 1'b0, "R1", "reset done", doneValid, 0);
    chk(!busWe && !busRe, "R4", "reset bus idle", {busWe, busRe}, 0);
    rstN = 1'b1;
    @(negedge clk);
    doReq(4'd0,  2'd0, 1'b1, 16'h1234, 3, 2, "R6");
    doReq(4'd5,  2'd2, 1'b0, 16'hABCD, 0, 0, "R2");
    doReq(4'd8,  2'd3, 1'b1, 16'h00FF, 4, 1, "R3");
    doReq(4'd15, 2'd1, 1'b1, 16'h9000, 1, 5, "R6");
    doReq(4'd10, 2'd0, 1'b0, 16'hFFFF, 2, 2, "R5");
    doReq(4'd3,  2'd1, 1'b0, 16'h5555, LIM, 0, "R7");
    doReq(4'd12, 2'd2, 1'b1, 16'h7777, 1, LIM, "R9");
    doReq(4'd7,  2'd3, 1'b1, 16'h4321, LIM - 1, LIM - 1, "R8");
    doReq(4'd9,  2'd2, 1'b0, 16'h0F0F, 0, LIM - 1, "R9");
    while (sb.size() != 0 || !reqReady) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule